// File: doc/BRIEF.md
# Rectangle Pixel Transfer Engine

This block moves a rectangle of 16-bit pixels between a host word stream and a 1024 × 512 pixel frame memory. A three-word command arrives on the input stream: an opcode word, a position word and a size word. A write opcode makes the engine take every following input word as two pixels and store them. A read opcode makes it fetch pixels and return them two to a word on the output stream. Pixels are visited row by row: the column offset advances per pixel, wraps back at the rectangle width, and then the row moves down by one, wrapping from 511 to 0.

Both word streams use valid/ready. An input word is taken on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. During a read, `in_ready_o` stays low, so input words wait until the read completes. An output word is handed off on an edge where `out_valid_o` and `out_ready_i` are both high. While the sink holds `out_ready_i` low, `out_valid_o` and `out_data_o` stay unchanged. The engine keeps its row offset, remaining-row count and half-word position in registers. A transfer can therefore be fed in bursts of any length with idle gaps between them.

The pixel memory port moves one pixel per cycle. Its read data returns one cycle after the request. The status pins `busy_o`, `img_ready_o` and `done_o` are plain levels or pulses. `abort_i` is a synchronous pulse that drops the transfer and any partly received command.

Top module: `rect_pixel_mover`

## Requirements
- R1: The opcode is bits 31:24 of the first command word. Codes 0xA0–0xBF start a write and codes 0xC0–0xDF start a read. Either starts only after two more words, the position word and then the size word. Any other opcode is consumed as a single word and has no effect: `busy_o` stays low and nothing reaches memory.
- R2: The start column is position-word bits 9:0. The start row is position-word bits 24:16.
- R3: Width is ((size bits 9:0) − 1 mod 1024) + 1 and height is ((size bits 24:16) − 1 mod 512) + 1. A zero field therefore means 1024 columns or 512 rows.
- R4: The pixel address is row·1024 + ((start column + offset) mod 1024). On a write, each input word stores its bits 15:0 first and its bits 31:16 at the next pixel position.
- R5: When the offset reaches the width it returns to 0. The row then advances by one modulo 512 and the remaining-row count drops by one.
- R6: On a read, bits 15:0 of an output word hold the pixel from the earlier position. If the pixel total is odd, the upper half of the last read word is zero, and the upper half of the last write word is never stored.
- R7: `img_ready_o` rises in the cycle after a read's size word is taken. It falls together with the completion of that read.
- R8: `busy_o` is high from the cycle after the size word until the transfer ends. `done_o` is a one-cycle pulse in the first cycle where `busy_o` is low again. A write ends after its last pixel store. A read ends at the handshake of its last word.
- R9: While a write is in progress, every input word is pixel data, even if its top byte looks like an opcode.
- R10: An `abort_i` pulse ends any transfer and clears `busy_o`, `img_ready_o` and `out_valid_o` in the next cycle. It also clears any partly received command, so the next word is treated as an opcode. No `done_o` pulse follows.
- R11: A held output word keeps `out_valid_o` high and `out_data_o` stable. `in_ready_o` is low throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Pulse that drops the transfer and any partial command |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Engine accepts the input word |
| in_data_i | input | 32 | Command or pixel-pair word |
| out_valid_o | output | 1 | Read word valid |
| out_ready_i | input | 1 | Sink accepts the read word |
| out_data_o | output | 32 | Read pixel pair |
| mem_req_o | output | 1 | Pixel memory access this cycle |
| mem_we_o | output | 1 | Access is a store |
| mem_addr_o | output | 19 | Pixel address, row·1024 + column |
| mem_wdata_o | output | 16 | Pixel to store |
| mem_rdata_i | input | 16 | Pixel read, one cycle after the request |
| busy_o | output | 1 | Transfer in progress |
| img_ready_o | output | 1 | A read transfer is in progress |
| done_o | output | 1 | One-cycle pulse at transfer end |

## Verification
`busy_o`, and for a read `img_ready_o`, are due one cycle after the edge that takes the size word. On a write, the two pixel stores of a word are issued on the two cycles after the word is taken. On a read, the output word appears three cycles after its first fetch, or two cycles when only one pixel is left. `done_o` comes one cycle after the last store or the last output handshake. The bench drives inputs and samples outputs on falling edges, so each of these results is read in the half-cycle after the edge that produced it. Completion is polled cycle by cycle, so a single-cycle pulse cannot be missed.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  // Opcode prefix in bits 7:5 of the command byte.
  localparam logic [2:0] OPC_TO_MEM   = 3'b101;
  localparam logic [2:0] OPC_FROM_MEM = 3'b110;

  // Fixed bit position of the second field in position and size words.
  localparam int FIELD_HI_LSB = 16;

  typedef enum logic [1:0] {
    P_OPC,
    P_POS,
    P_SIZ
  } parse_e;

  typedef enum logic [2:0] {
    S_CMD,
    S_WR,
    S_RLO,
    S_RHI,
    S_RWAIT,
    S_ROUT
  } eng_e;

endpackage

// File: rtl/rpm_cmd_parse.sv
module rpm_cmd_parse
  import rpm_pkg::*;
#(
  parameter int XW     = 10,
  parameter int YW     = 9,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              start,
  output logic              start_rd,
  output logic [XW-1:0]     x0,
  output logic [YW-1:0]     y0,
  output logic [XW:0]       w0,
  output logic [YW:0]       h0
);

  localparam logic [XW-1:0] X_ONE  = 1;
  localparam logic [YW-1:0] Y_ONE  = 1;
  localparam logic [XW:0]   WX_ONE = 1;
  localparam logic [YW:0]   HY_ONE = 1;

  parse_e        p_q;
  logic          rd_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  logic [2:0]    op_pfx;
  logic [XW-1:0] w_m1;
  logic [YW-1:0] h_m1;
  logic          unused_word;

  assign op_pfx      = word[WORD_W-1 -: 3];
  assign w_m1        = word[XW-1:0] - X_ONE;
  assign h_m1        = word[FIELD_HI_LSB +: YW] - Y_ONE;
  assign unused_word = ^word;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      p_q  <= P_OPC;
      rd_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else if (take) begin
      unique case (p_q)
        P_OPC: begin
          if (op_pfx == OPC_TO_MEM || op_pfx == OPC_FROM_MEM) begin
            rd_q <= (op_pfx == OPC_FROM_MEM);
            p_q  <= P_POS;
          end
        end
        P_POS: begin
          x_q <= word[XW-1:0];
          y_q <= word[FIELD_HI_LSB +: YW];
          p_q <= P_SIZ;
        end
        default: p_q <= P_OPC;
      endcase
    end
  end

  assign start    = take && (p_q == P_SIZ);
  assign start_rd = rd_q;
  assign x0       = x_q;
  assign y0       = y_q;
  assign w0       = {1'b0, w_m1} + WX_ONE;
  assign h0       = {1'b0, h_m1} + HY_ONE;

endmodule

// File: rtl/rpm_raster.sv
module rpm_raster #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            load,
  input  logic [XW-1:0]   x0,
  input  logic [YW-1:0]   y0,
  input  logic [XW:0]     w0,
  input  logic [YW:0]     h0,
  input  logic            step,
  output logic [XW+YW-1:0] addr,
  output logic            last_pix,
  output logic            live
);

  localparam logic [XW-1:0] X_ONE   = 1;
  localparam logic [YW-1:0] Y_ONE   = 1;
  localparam logic [XW:0]   WX_ONE  = 1;
  localparam logic [YW:0]   ROW_ONE = 1;

  logic [XW-1:0] x_q;
  logic [XW-1:0] off_q;
  logic [YW-1:0] y_q;
  logic [XW:0]   wd_q;
  logic [YW:0]   rows_q;
  logic          row_end;
  logic [XW-1:0] col;

  assign row_end = ({1'b0, off_q} == (wd_q - WX_ONE));
  assign col     = x_q + off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      off_q  <= '0;
      y_q    <= '0;
      wd_q   <= WX_ONE;
      rows_q <= '0;
    end else if (clear) begin
      rows_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      x_q    <= x0;
      y_q    <= y0;
      wd_q   <= w0;
      rows_q <= h0;
      off_q  <= '0;
    end else if (step) begin
      if (row_end) begin
        off_q  <= '0;
        y_q    <= y_q + Y_ONE;
        rows_q <= rows_q - ROW_ONE;
      end else begin
        off_q <= off_q + X_ONE;
      end
    end
  end

  assign addr     = {y_q, col};
  assign live     = (rows_q != '0);
  assign last_pix = row_end && (rows_q == ROW_ONE);

endmodule

// File: rtl/rpm_rd_pack.sv
module rpm_rd_pack #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          issue,
  input  logic          issue_hi,
  input  logic [PW-1:0] rdata,
  output logic [2*PW-1:0] word
);

  logic pend_v_q;
  logic pend_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q  <= 1'b0;
      pend_hi_q <= 1'b0;
    end else begin
      pend_v_q  <= issue;
      pend_hi_q <= issue_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clr) begin
      word <= '0;
    end else if (pend_v_q) begin
      if (pend_hi_q) word[2*PW-1:PW] <= rdata;
      else           word[PW-1:0]    <= rdata;
    end
  end

endmodule

// File: rtl/rect_pixel_mover.sv
module rect_pixel_mover
  import rpm_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int PIX_W  = 16,
  localparam int WORD_W = 2 * PIX_W,
  localparam int ADDR_W = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  output logic              busy_o,
  output logic              img_ready_o,
  output logic              done_o
);

  eng_e              state_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_full_q;
  logic              phase_q;
  logic              img_q;
  logic              done_q;

  logic              cmd_take;
  logic              wr_take;
  logic              start;
  logic              start_rd;
  logic [X_BITS-1:0] x0;
  logic [Y_BITS-1:0] y0;
  logic [X_BITS:0]   w0;
  logic [Y_BITS:0]   h0;
  logic              last_pix;
  logic              live;
  logic              wr_fire;
  logic              rd_issue;
  logic              step;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] rd_word;

  // Input acceptance: always in command mode, during a write whenever
  // the holding word is free or is being emptied by its upper pixel.
  always_comb begin
    in_ready_o = 1'b0;
    if (state_q == S_CMD)
      in_ready_o = 1'b1;
    else if (state_q == S_WR)
      in_ready_o = !hold_full_q || (phase_q && !last_pix);
  end

  assign cmd_take = (state_q == S_CMD) && in_valid_i;
  assign wr_take  = (state_q == S_WR) && in_valid_i && in_ready_o;

  rpm_cmd_parse #(
    .XW     (X_BITS),
    .YW     (Y_BITS),
    .WORD_W (WORD_W)
  ) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (abort_i),
    .take     (cmd_take),
    .word     (in_data_i),
    .start    (start),
    .start_rd (start_rd),
    .x0       (x0),
    .y0       (y0),
    .w0       (w0),
    .h0       (h0)
  );

  assign wr_fire  = (state_q == S_WR) && hold_full_q;
  assign rd_issue = (state_q == S_RLO) || ((state_q == S_RHI) && live);
  assign step     = wr_fire || rd_issue;

  rpm_raster #(
    .XW (X_BITS),
    .YW (Y_BITS)
  ) u_raster (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (abort_i),
    .load     (start && !abort_i),
    .x0       (x0),
    .y0       (y0),
    .w0       (w0),
    .h0       (h0),
    .step     (step && !abort_i),
    .addr     (addr),
    .last_pix (last_pix),
    .live     (live)
  );

  rpm_rd_pack #(
    .PW (PIX_W)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state_q == S_RLO),
    .issue    (rd_issue),
    .issue_hi (state_q == S_RHI),
    .rdata    (mem_rdata_i),
    .word     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) begin
      state_q     <= S_CMD;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      phase_q     <= 1'b0;
      img_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_CMD: begin
          if (start) begin
            state_q     <= start_rd ? S_RLO : S_WR;
            img_q       <= start_rd;
            hold_full_q <= 1'b0;
            phase_q     <= 1'b0;
          end
        end
        S_WR: begin
          if (wr_fire && last_pix) begin
            state_q     <= S_CMD;
            hold_full_q <= 1'b0;
            phase_q     <= 1'b0;
            done_q      <= 1'b1;
          end else if (wr_take) begin
            hold_q      <= in_data_i;
            hold_full_q <= 1'b1;
            phase_q     <= 1'b0;
          end else if (wr_fire) begin
            if (phase_q) hold_full_q <= 1'b0;
            phase_q <= !phase_q;
          end
        end
        S_RLO:   state_q <= last_pix ? S_RWAIT : S_RHI;
        S_RHI:   state_q <= S_RWAIT;
        S_RWAIT: state_q <= S_ROUT;
        S_ROUT: begin
          if (out_ready_i) begin
            if (live) begin
              state_q <= S_RLO;
            end else begin
              state_q <= S_CMD;
              img_q   <= 1'b0;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= S_CMD;
      endcase
    end
  end

  assign mem_req_o   = step;
  assign mem_we_o    = wr_fire;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = phase_q ? hold_q[WORD_W-1:PIX_W] : hold_q[PIX_W-1:0];
  assign out_valid_o = (state_q == S_ROUT);
  assign out_data_o  = rd_word;
  assign busy_o      = (state_q != S_CMD);
  assign img_ready_o = img_q;
  assign done_o      = done_q;

endmodule

// File: rtl/rpm_checks.sv
module rpm_checks #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              busy_o,
  input logic              img_ready_o,
  input logic              done_o
);

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !img_ready_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !abort_i) |=> (out_valid_o && $stable(out_data_o))); // R11

  AST_READ_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready_o |-> (!in_ready_o && !mem_we_o)); // R7

  AST_IMG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready_o |-> busy_o); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !img_ready_o && !out_valid_o && !done_o)); // R10

  AST_OUT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !mem_req_o); // R11

endmodule

bind rect_pixel_mover rpm_checks #(.WORD_W(WORD_W)) u_rpm_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .busy_o      (busy_o),
  .img_ready_o (img_ready_o),
  .done_o      (done_o)
);

// File: tb/sim_rect_pixel_mover.sv
`timescale 1ns/1ps
module sim_rect_pixel_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [18:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic        busy_o;
  logic        img_ready_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int wcount = 0;
  int cyc    = 0;
  logic [15:0] vmem [int];

  always #4 clk = ~clk;

  rect_pixel_mover u0 (
    .clk (clk), .rst_n (rst_n), .abort_i (abort_i),
    .in_valid_i (in_valid_i), .in_ready_o (in_ready_o), .in_data_i (in_data_i),
    .out_valid_o (out_valid_o), .out_ready_i (out_ready_i), .out_data_o (out_data_o),
    .mem_req_o (mem_req_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
    .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i),
    .busy_o (busy_o), .img_ready_o (img_ready_o), .done_o (done_o)
  );

  // Pixel memory model: registered read, one cycle latency.
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        vmem[int'(mem_addr_o)] = mem_wdata_o;
        wcount = wcount + 1;
      end else begin
        mem_rdata_i <= vmem.exists(int'(mem_addr_o)) ? vmem[int'(mem_addr_o)] : 16'h0000;
      end
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int paddr(int x, int y, int off, int row);
    return ((y + row) % 512) * 1024 + ((x + off) % 1024);
  endfunction

  function automatic logic [31:0] memv(int a);
    return vmem.exists(a) ? {16'h0000, vmem[a]} : 32'hDEAD0000;
  endfunction

  task automatic send_word(input logic [31:0] d);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = d;
    while (!in_ready_o) @(negedge clk);
    @(posedge clk);
    #1 in_valid_i = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input int x, input int y, input int wf, input int hf);
    send_word({op, 24'h0});
    send_word({7'b0, y[8:0], 6'b0, x[9:0]});
    send_word({7'b0, hf[8:0], 6'b0, wf[9:0]});
  endtask

  task automatic wait_done(input string tag, input int maxc);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    chk(tag, "done pulse", {31'b0, seen}, 32'd1);
    chk(tag, "busy after done", {31'b0, busy_o}, 32'd0);
  endtask

  task automatic recv_word(input int stall, output logic [31:0] d);
    @(negedge clk);
    while (!out_valid_o) @(negedge clk);
    d = out_data_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R11", "held valid", {31'b0, out_valid_o}, 32'd1);
      chk("R11", "held data", out_data_o, d);
      chk("R11", "in_ready in read", {31'b0, in_ready_o}, 32'd0);
    end
    out_ready_i = 1'b1;
    @(posedge clk);
    #1 out_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8", "reset busy", {31'b0, busy_o}, 32'd0);
    chk("R7", "reset img", {31'b0, img_ready_o}, 32'd0);
    chk("R11", "reset out_valid", {31'b0, out_valid_o}, 32'd0);
    chk("R1", "reset in_ready", {31'b0, in_ready_o}, 32'd1);
    chk("R8", "reset done", {31'b0, done_o}, 32'd0);
    chk("R4", "reset mem_req", {31'b0, mem_req_o}, 32'd0);
  endtask

  task automatic t_write_basic;
    logic [15:0] p [8];
    wcount = 0;
    for (int i = 0; i < 8; i++) p[i] = 16'h1100 + 16'(i);
    send_cmd(8'hA0, 5, 3, 4, 2);
    @(negedge clk);
    chk("R8", "busy after size word", {31'b0, busy_o}, 32'd1);
    chk("R7", "img low on write", {31'b0, img_ready_o}, 32'd0);
    for (int k = 0; k < 4; k++) send_word({p[2*k+1], p[2*k]});
    wait_done("R8", 20);
    chk("R4", "store count", wcount, 32'd8);
    for (int i = 0; i < 8; i++)
      chk("R2_R4_R5", "stored pixel", memv(paddr(5, 3, i % 4, i / 4)), {16'h0, p[i]});
  endtask

  task automatic t_write_wrap;
    logic [15:0] p [6];
    wcount = 0;
    p[0] = 16'h0101; p[1] = 16'hA022; p[2] = 16'h0303;
    p[3] = 16'hC044; p[4] = 16'h0505; p[5] = 16'h0606;
    send_cmd(8'hBF, 1022, 511, 3, 2);
    for (int k = 0; k < 3; k++) send_word({p[2*k+1], p[2*k]});
    wait_done("R9", 20);
    chk("R9", "opcode-like data stored", wcount, 32'd6);
    for (int i = 0; i < 6; i++)
      chk("R5", "wrapped pixel", memv(paddr(1022, 511, i % 3, i / 3)), {16'h0, p[i]});
    chk("R5", "row 0 col 0", memv(0), 32'h0000_0606);
  endtask

  task automatic t_write_odd;
    wcount = 0;
    vmem[paddr(200, 40, 3, 0)] = 16'h5A5A;
    send_cmd(8'hA7, 200, 40, 3, 1);
    send_word(32'h2222_1111);
    send_word(32'h4444_3333);
    wait_done("R6", 20);
    chk("R6", "odd write count", wcount, 32'd3);
    chk("R6", "third pixel", memv(paddr(200, 40, 2, 0)), 32'h0000_3333);
    chk("R6", "dropped upper half", memv(paddr(200, 40, 3, 0)), 32'h0000_5A5A);
  endtask

  task automatic t_read_block;
    logic [31:0] d;
    logic [15:0] e [6];
    for (int i = 0; i < 6; i++) begin
      e[i] = 16'h7000 + 16'((i / 3) << 8) + 16'(i % 3);
      vmem[paddr(10, 20, i % 3, i / 3)] = e[i];
    end
    send_cmd(8'hC0, 10, 20, 3, 2);
    @(negedge clk);
    chk("R7", "img after size word", {31'b0, img_ready_o}, 32'd1);
    chk("R11", "in_ready low in read", {31'b0, in_ready_o}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      recv_word(k == 1 ? 3 : 0, d);
      chk("R6", "read word", d, {e[2*k+1], e[2*k]});
      if (k < 2) chk("R7", "img during read", {31'b0, img_ready_o}, 32'd1);
    end
    wait_done("R7", 10);
    chk("R7", "img cleared", {31'b0, img_ready_o}, 32'd0);
  endtask

  task automatic t_read_single;
    logic [31:0] d;
    vmem[paddr(1023, 511, 0, 0)] = 16'hBEEF;
    send_cmd(8'hDF, 1023, 511, 1, 1);
    recv_word(2, d);
    chk("R6", "single pixel upper zero", d, 32'h0000_BEEF);
    wait_done("R8", 10);
  endtask

  task automatic t_zero_width;
    wcount = 0;
    send_cmd(8'hA0, 100, 7, 0, 1);
    for (int k = 0; k < 512; k++) send_word({16'(2*k+1), 16'(2*k)});
    wait_done("R3", 20);
    chk("R3", "1024 stores", wcount, 32'd1024);
    chk("R3", "last column wraps", memv(paddr(100, 7, 1023, 0)), 32'd1023);
    chk("R3", "first column", memv(paddr(100, 7, 0, 0)), 32'd0);
    chk("R3", "row below untouched", memv(paddr(100, 7, 0, 1)), 32'hDEAD0000);
  endtask

  task automatic t_zero_height;
    wcount = 0;
    send_cmd(8'hA0, 3, 5, 1, 0);
    for (int k = 0; k < 256; k++) send_word({16'(2*k+1), 16'(2*k)});
    wait_done("R3", 20);
    chk("R3", "512 stores", wcount, 32'd512);
    chk("R3", "row 511 steps", memv(paddr(3, 5, 0, 511)), 32'd511);
    chk("R3", "row 5 first", memv(paddr(3, 5, 0, 0)), 32'd0);
  endtask

  task automatic t_ignored;
    wcount = 0;
    send_word(32'h0200_0000);
    send_word(32'hE123_4567);
    send_word(32'h8000_0000);
    @(negedge clk);
    chk("R1", "foreign opcodes busy", {31'b0, busy_o}, 32'd0);
    chk("R1", "foreign opcodes ready", {31'b0, in_ready_o}, 32'd1);
    chk("R1", "foreign opcodes no store", wcount, 32'd0);
    send_cmd(8'hA0, 600, 300, 2, 1);
    send_word(32'h0BB0_0AA0);
    wait_done("R1", 10);
    chk("R1", "fresh write lo", memv(paddr(600, 300, 0, 0)), 32'h0000_0AA0);
    chk("R1", "fresh write hi", memv(paddr(600, 300, 1, 0)), 32'h0000_0BB0);
  endtask

  task automatic pulse_abort;
    @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  task automatic t_abort;
    logic seen;
    send_cmd(8'hC3, 0, 0, 8, 8);
    repeat (2) @(negedge clk);
    pulse_abort();
    chk("R10", "busy cleared", {31'b0, busy_o}, 32'd0);
    chk("R10", "img cleared", {31'b0, img_ready_o}, 32'd0);
    chk("R10", "out_valid cleared", {31'b0, out_valid_o}, 32'd0);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    chk("R10", "no done after abort", {31'b0, seen}, 32'd0);
    send_word({8'hA0, 24'h0});
    pulse_abort();
    wcount = 0;
    send_cmd(8'hA0, 40, 60, 2, 1);
    send_word(32'h0D0D_0C0C);
    wait_done("R10", 10);
    chk("R10", "partial command dropped", wcount, 32'd2);
    chk("R10", "post-abort write", memv(paddr(40, 60, 1, 0)), 32'h0000_0D0D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_basic();
    t_write_wrap();
    t_write_odd();
    t_read_block();
    t_read_single();
    t_zero_width();
    t_zero_height();
    t_ignored();
    t_abort();
    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule